// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a four-wire serial stereo audio stream into parallel sample pairs. The four wires are a bit clock, a left/right clock, a word clock and one serial data line. They are oversampled by the fast system clock, so the outputs and the strobe all sit in the system clock domain. The serial bit clock must run at no more than a quarter of the system clock rate.

Static configuration inputs set four things: which of the two framing clocks marks the start of a word, whether the first data bit lines up with that marker or comes one bit clock later, which bit clock edge is the sampling edge, and how many bits a word carries. Every received word is placed at the top of a 24-bit output, and the low bits it does not fill are zero. After the right word of a frame is complete, the left and right results are presented together with a one-cycle valid strobe.

Top module: `sai_rx`

## Requirements
- R1: `cfg_len` sets the word length in bits. Values 4 to 20 are used as given. Values below 4 act as 4 and values above 20 act as 20.
- R2: A word of length L appears in bits 23 down to 24-L of its output. All bits below 24-L read zero.
- R3: Data arrives most significant bit first. The first bit of a word lands in output bit 23.
- R4: With `cfg_wc_frame`=0, a word starts when the left/right clock level sampled at an active edge differs from the level sampled at the previous active edge. With `cfg_late`=0 the data bit sampled at that same edge is the first bit. With `cfg_late`=1 the first bit is taken at the next active edge.
- R5: With `cfg_wc_frame`=1, a word starts when the word clock is sampled high at an active edge after being sampled low at the previous one. The same `cfg_late` rule applies.
- R6: `cfg_fall_edge`=0 samples all serial inputs on bit clock rising edges. `cfg_fall_edge`=1 samples them on falling edges.
- R7: The channel of a word comes from the left/right clock level sampled at the edge that starts the word. With `cfg_late`=0, high means left. With `cfg_late`=1, low means left.
- R8: Once L bits of a word have been taken, further data bits are ignored until the next word start.
- R9: `sample_valid` pulses for exactly one system clock cycle when a right word completes after a left word in the same frame. `left_out` and `right_out` change only in that cycle and otherwise hold. A right word with no left word before it is dropped.
- R10: A synchronous active-high `rst` clears `left_out` and `right_out` to zero and holds `sample_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wc_frame | input | 1 | 0: frame on the left/right clock; 1: frame on the word clock rising edge |
| cfg_late | input | 1 | 1: first data bit comes one bit clock after the framing marker |
| cfg_fall_edge | input | 1 | 1: sample on falling bit clock edges |
| cfg_len | input | 5 | Word length in bits, clamped to 4..20 |
| ser_bclk | input | 1 | Serial bit clock |
| ser_lrclk | input | 1 | Serial left/right clock |
| ser_wclk | input | 1 | Serial word clock |
| ser_data | input | 1 | Serial data |
| left_out | output | 24 | Left sample, left-aligned |
| right_out | output | 24 | Right sample, left-aligned |
| sample_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The bench runs six configurations. Together they cover both framing clocks, both first-bit positions, both bit clock edges, a short length, a mid length, the full length and two out-of-range lengths. Each slot is padded with ones after the word, so any bit taken past the configured length shows up as a nonzero low bit. One frame per run uses all-ones words, which exposes placement and zero-fill errors. The other frames use mixed patterns, which expose bit order and left/right swaps. A wrong edge choice or a wrong first-bit position moves every word by one bit, so the compared values differ.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

    localparam int unsigned OUT_W   = 24;
    localparam int unsigned MIN_LEN = 4;
    localparam int unsigned MAX_LEN = 20;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
    localparam int unsigned POS_W   = $clog2(OUT_W);

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

    typedef struct packed {
        logic data;
        logic lr;
        logic wc;
    } ser_bits_t;

    typedef struct packed {
        logic             done;
        chan_e            chan;
        logic [OUT_W-1:0] word;
    } word_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req);
        if (int'(req) < int'(MIN_LEN))      return LEN_W'(MIN_LEN);
        else if (int'(req) > int'(MAX_LEN)) return LEN_W'(MAX_LEN);
        else                                return req;
    endfunction

    function automatic logic [OUT_W-1:0] fill_mask(input logic [LEN_W-1:0] len);
        logic [OUT_W-1:0] m;
        for (int i = 0; i < int'(OUT_W); i++)
            m[i] = (i < int'(OUT_W) - int'(len));
        return m;
    endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sai_rx_tap.sv
module sai_rx_tap
    import sai_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fall_sel,
    input  logic      bclk_s,
    input  ser_bits_t bits_s,
    output logic      act,
    output ser_bits_t bits_act
);
    logic bclk_q;
    logic edge_hit;

    always_comb begin
        if (fall_sel) edge_hit = bclk_q & ~bclk_s;
        else          edge_hit = ~bclk_q & bclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            act      <= 1'b0;
            bits_act <= '0;
        end else begin
            bclk_q <= bclk_s;
            act    <= edge_hit;
            if (edge_hit) bits_act <= bits_s;
        end
    end
endmodule

// File: rtl/sai_rx_framer.sv
module sai_rx_framer
    import sai_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             act,
    input  ser_bits_t        bits,
    input  logic             cfg_wc_frame,
    input  logic             cfg_late,
    input  logic [LEN_W-1:0] len,
    output word_t            wout
);
    logic             lr_prev, wc_prev;
    logic             pend, capturing;
    chan_e            pend_ch, cur_ch;
    logic [LEN_W-1:0] idx;
    logic [OUT_W-1:0] acc, acc_nxt, acc_first;
    logic [POS_W-1:0] pos;
    logic             mark;
    chan_e            mark_ch;

    always_comb begin
        mark      = cfg_wc_frame ? (bits.wc & ~wc_prev) : (bits.lr ^ lr_prev);
        mark_ch   = chan_e'(bits.lr ^ cfg_late);
        pos       = POS_W'(int'(OUT_W) - 1 - int'(idx));
        acc_nxt   = acc;
        acc_nxt[pos] = bits.data;
        acc_first = '0;
        acc_first[OUT_W-1] = bits.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_prev   <= 1'b0;
            wc_prev   <= 1'b0;
            pend      <= 1'b0;
            pend_ch   <= CH_RIGHT;
            capturing <= 1'b0;
            cur_ch    <= CH_RIGHT;
            idx       <= '0;
            acc       <= '0;
            wout      <= '0;
        end else begin
            wout.done <= 1'b0;
            if (act) begin
                lr_prev <= bits.lr;
                wc_prev <= bits.wc;
                if (mark && !cfg_late) begin
                    acc       <= acc_first;
                    idx       <= LEN_W'(1);
                    cur_ch    <= mark_ch;
                    capturing <= 1'b1;
                    pend      <= 1'b0;
                end else if (mark) begin
                    pend      <= 1'b1;
                    pend_ch   <= mark_ch;
                    capturing <= 1'b0;
                end else if (pend) begin
                    pend      <= 1'b0;
                    acc       <= acc_first;
                    idx       <= LEN_W'(1);
                    cur_ch    <= pend_ch;
                    capturing <= 1'b1;
                end else if (capturing) begin
                    acc <= acc_nxt;
                    idx <= idx + LEN_W'(1);
                    if (idx + LEN_W'(1) == len) begin
                        capturing <= 1'b0;
                        wout.done <= 1'b1;
                        wout.chan <= cur_ch;
                        wout.word <= acc_nxt;
                    end
                end
            end
        end
    end

    // R8: a word in progress never holds more than the configured count
    p_idx_bound_r8: assert property (@(posedge clk) disable iff (rst)
        capturing |-> (idx < len));
endmodule

// File: rtl/sai_rx.sv
module sai_rx
    import sai_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wc_frame,
    input  logic             cfg_late,
    input  logic             cfg_fall_edge,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             ser_bclk,
    input  logic             ser_lrclk,
    input  logic             ser_wclk,
    input  logic             ser_data,
    output logic [OUT_W-1:0] left_out,
    output logic [OUT_W-1:0] right_out,
    output logic             sample_valid
);
    localparam int unsigned NWIRE = 4;

    logic [NWIRE-1:0] wires_s;
    ser_bits_t        bits_s, bits_act;
    logic             act;
    logic [LEN_W-1:0] len_c;
    word_t            wrd;
    logic             have_left;
    logic [OUT_W-1:0] left_hold;

    assign len_c = clamp_len(cfg_len);

    sai_rx_sync #(.W(NWIRE), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({ser_bclk, ser_data, ser_lrclk, ser_wclk}),
        .d_out (wires_s)
    );

    assign bits_s = '{data: wires_s[2], lr: wires_s[1], wc: wires_s[0]};

    sai_rx_tap u_tap (
        .clk      (clk),
        .rst      (rst),
        .fall_sel (cfg_fall_edge),
        .bclk_s   (wires_s[3]),
        .bits_s   (bits_s),
        .act      (act),
        .bits_act (bits_act)
    );

    sai_rx_framer u_framer (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .bits         (bits_act),
        .cfg_wc_frame (cfg_wc_frame),
        .cfg_late     (cfg_late),
        .len          (len_c),
        .wout         (wrd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            have_left    <= 1'b0;
            left_hold    <= '0;
            left_out     <= '0;
            right_out    <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (wrd.done) begin
                if (wrd.chan == CH_LEFT) begin
                    left_hold <= wrd.word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_out     <= left_hold;
                    right_out    <= wrd.word;
                    sample_valid <= 1'b1;
                    have_left    <= 1'b0;
                end
            end
        end
    end

    // R9: strobe lasts one cycle
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R9: outputs move only together with the strobe
    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((left_out != $past(left_out)) || (right_out != $past(right_out))) |-> sample_valid);

    // R2: bits under a short word stay zero
    p_zero_fill_r2: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (((left_out | right_out) & fill_mask(len_c)) == '0));
endmodule

// File: tb/sai_rx_tb.sv
module sai_rx_tb;
    import sai_rx_pkg::*;

    localparam int HALF = 4;
    localparam int SLOT = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wc_frame = 1'b0, cfg_late = 1'b0, cfg_fall_edge = 1'b0;
    logic [LEN_W-1:0] cfg_len = 5'd16;
    logic             ser_bclk = 1'b0, ser_lrclk = 1'b0, ser_wclk = 1'b0, ser_data = 1'b0;
    logic [OUT_W-1:0] left_out, right_out;
    logic             sample_valid;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R10";
    bit    done_run = 0;
    logic [2*OUT_W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    sai_rx u_dut (
        .clk(clk), .rst(rst),
        .cfg_wc_frame(cfg_wc_frame), .cfg_late(cfg_late),
        .cfg_fall_edge(cfg_fall_edge), .cfg_len(cfg_len),
        .ser_bclk(ser_bclk), .ser_lrclk(ser_lrclk),
        .ser_wclk(ser_wclk), .ser_data(ser_data),
        .left_out(left_out), .right_out(right_out),
        .sample_valid(sample_valid)
    );

    task automatic check(input string req, input logic [OUT_W-1:0] act_v,
                         input logic [OUT_W-1:0] exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // scoreboard monitor
    logic valid_seen_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && sample_valid) begin
            if (valid_seen_prev) check("R9 strobe width", 24'd1, 24'd0);
            if (exp_q.size() == 0) begin
                check({cur_tag, " R9 unexpected strobe"}, 24'd1, 24'd0);
            end else begin
                logic [2*OUT_W-1:0] e;
                e = exp_q.pop_front();
                check({cur_tag, " R2 R3 R7 R8 left"},  left_out,  e[2*OUT_W-1:OUT_W]);
                check({cur_tag, " R2 R3 R7 R8 right"}, right_out, e[OUT_W-1:0]);
            end
        end
        valid_seen_prev = !rst && sample_valid;
    end

    task automatic drive_bit(input logic d, input logic lr, input logic wc);
        ser_bclk  = cfg_fall_edge ? 1'b1 : 1'b0;
        ser_data  = d;
        ser_lrclk = lr;
        ser_wclk  = wc;
        repeat (HALF) @(negedge clk);
        ser_bclk  = cfg_fall_edge ? 1'b0 : 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_slot(input logic [OUT_W-1:0] w, input int len, input logic lvl);
        for (int i = 0; i < SLOT; i++) begin
            int  j;
            logic d;
            j = i - (cfg_late ? 1 : 0);
            d = (j >= 0 && j < len) ? w[len-1-j] : 1'b1;
            drive_bit(d, lvl, (i == 0));
        end
    endtask

    function automatic logic [OUT_W-1:0] gen(input int s, input int f, input int c, input int len);
        logic [OUT_W-1:0] v;
        v = (f == 0) ? '1 : OUT_W'(s * 40503 + f * 2654 + c * 977 + 12345);
        return v & ((OUT_W'(1) << len) - OUT_W'(1));
    endfunction

    task automatic run_group(input string tag, input logic wc, input logic late,
                             input logic fall, input logic [LEN_W-1:0] lcfg, input int seed);
        int   eff;
        logic lft_lvl, rgt_lvl;
        cur_tag       = tag;
        cfg_wc_frame  = wc;
        cfg_late      = late;
        cfg_fall_edge = fall;
        cfg_len       = lcfg;
        ser_bclk      = fall ? 1'b1 : 1'b0;
        rgt_lvl       = late;
        lft_lvl       = ~late;
        ser_lrclk     = rgt_lvl;
        ser_wclk      = 1'b0;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 left after reset",  left_out,  '0);
        check("R10 right after reset", right_out, '0);
        check("R10 strobe after reset", {23'd0, sample_valid}, '0);
        // R1: effective length is the clamped request
        eff = int'(lcfg) < int'(MIN_LEN) ? int'(MIN_LEN) :
              (int'(lcfg) > int'(MAX_LEN) ? int'(MAX_LEN) : int'(lcfg));
        for (int k = 0; k < 3; k++) drive_bit(1'b0, rgt_lvl, 1'b0);
        for (int f = 0; f < 3; f++) begin
            logic [OUT_W-1:0] lw, rw;
            lw = gen(seed, f, 0, eff);
            rw = gen(seed, f, 1, eff);
            exp_q.push_back({lw << (OUT_W - eff), rw << (OUT_W - eff)});
            send_slot(lw, eff, lft_lvl);
            send_slot(rw, eff, rgt_lvl);
        end
        for (int k = 0; k < 4; k++) drive_bit(1'b0, rgt_lvl, 1'b0);
        check({tag, " R9 pending pairs"}, OUT_W'(exp_q.size()), '0);
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 initial left",  left_out,  '0);
        check("R10 initial right", right_out, '0);
        run_group("R4 R6 rise len16",          1'b0, 1'b0, 1'b0, 5'd16, 1);
        run_group("R4 R6 late fall len20",     1'b0, 1'b1, 1'b1, 5'd20, 2);
        run_group("R5 rise len4",              1'b1, 1'b0, 1'b0, 5'd4,  3);
        run_group("R5 R6 late fall len12",     1'b1, 1'b1, 1'b1, 5'd12, 4);
        run_group("R1 R4 len2 clamps to 4",    1'b0, 1'b0, 1'b0, 5'd2,  5);
        run_group("R1 R4 late len31 clamps 20",1'b0, 1'b1, 1'b0, 5'd31, 6);
        done_run = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule